// File: doc/BRIEF.md
# Candidate circuit fitness scorer

The scorer gives one integer score to a candidate feed-forward circuit made of programmable nodes. After a start pulse it reads the node and output genes through a chromosome read port. It marks the nodes that the outputs actually reach, adds up the transistor cost of those nodes, counts them as gates and finds the deepest gate path. While this runs, it accepts one beat per input vector on a valid/ready stream. Each beat carries the observed and the expected output bits, and the scorer counts the bits that differ.

When both parts have finished, the four terms are folded into one number. The error term carries the largest weight, then transistors, then gates, then delay. The weights are chosen so that a lower-priority term can never outweigh one unit of a higher-priority term. The result is held on `fitness`, and `done` pulses once. Evaluating the nodes and running the search are left to neighbouring blocks.

On the vector stream a beat is transferred in a cycle where `vec_valid` and `vec_ready` are both high. The producer may hold `vec_valid` low for any number of cycles. `vec_ready` does not depend on `vec_valid`. It is high only while a job is running and fewer than 2^NI beats have been taken. It falls for good after the last beat, so any further beat is simply left waiting.

Top module: `fit_scorer`

## Requirements
- R1: After reset `busy` and `done` are 0. A `start` pulse while idle raises `busy` on the next cycle. When the job finishes, `busy` falls and `done` is high for exactly one cycle in that same cycle. A `start` seen while `busy` is high is ignored, and the running job completes unchanged with a single `done`.
- R2: The chromosome is read combinationally and `chr_addr` always stays below NN+NO. Address k < NN holds node k as {func[3:0], src2, src1, src0}, each source IW = clog2(NI+NN) bits wide with src0 in the low bits. Address NN+j holds the source of output j in its low IW bits. A source value below NI names a primary input, and a value NI+m names node m.
- R3: `vec_ready` is high only while busy and until exactly 2^NI beats have been accepted. It is low from then on until the next start.
- R4: The error term a is the total number of bit positions where `vec_obs` differs from `vec_exp`, summed over all accepted beats.
- R5: A node is active when an output gene names it, or when it is named by a used source field of an active node. The gate count c is the number of active nodes whose func code is below 14. Outputs that name primary inputs activate nothing.
- R6: The transistor count b is the sum of the costs of the active nodes. The cost for each func code is: 0 two-input AND 6, 1 three-input AND 8, 2 two-input OR 6, 3 three-input OR 8, 4 inverter 2, 5 two-input XOR 10, 6 three-input XOR 12, 7 two-input NAND 4, 8 three-input NAND 6, 9 two-input NOR 4, 10 three-input NOR 6, 11 multiplexer 6, 12 select-NAND-else-NOR 10, 13 select-NOR-else-NAND 8.
- R7: Code 4 uses only src0. Codes 0, 2, 5, 7 and 9 use src0 and src1. All other codes below 14 use all three sources. Fields that a node does not use never activate anything and never add delay.
- R8: The depth of a node is one more than the largest depth among the nodes its used sources name, where primary inputs have depth 0. The delay term d is the largest depth among the nodes named by the output genes, and it is 0 when every output names a primary input.
- R9: With G1 = NN+1, G2 = G1*G1 and G3 = (16*NN+1)*G2, the result is `fitness` = 1 + a*G3 + b*G2 + c*G1 + d on 48 bits. It is 0 after reset, it is loaded in the cycle that `done` rises, and it holds until the next job ends.
- R10: Func codes 14 and 15 make a constant node. It uses no sources, costs 0 transistors, is not counted as a gate and has depth 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin scoring one candidate |
| busy | output | 1 | A job is running |
| done | output | 1 | One-cycle pulse when `fitness` is updated |
| fitness | output | FITW | Weighted score of the last candidate |
| chr_addr | output | clog2(NN+NO) | Gene address |
| chr_data | input | 4+3*IW | Gene word at `chr_addr`, same cycle |
| vec_valid | input | 1 | A vector beat is offered |
| vec_ready | output | 1 | The scorer takes a beat this cycle |
| vec_obs | input | NO | Observed output bits of the vector |
| vec_exp | input | NO | Expected output bits of the vector |

## Verification
The bench goes after an inverter whose unused source fields point at a real node. A scorer that ignored arity would mark that node and inflate b, c and d. It runs a chain of two-input gates through every node, so that a depth update off by one or reading the wrong source would show up as a wrong delay. It also builds a circuit that drives a select gate from a constant node, to catch a constant node that is wrongly charged or counted. A circuit whose outputs come straight from inputs, scored with matching vectors, must give exactly 1. Random chromosomes are scored with vector streams that stall at random, and all-wrong vectors are scored too, so that a lost or double-counted beat changes the error term. One job gets a second start while it runs, which would corrupt or restart a scorer that did not ignore it.

// File: rtl/fit_pkg.sv
package fit_pkg;

  localparam int FUNC_W = 4;

  localparam logic [3:0] FN_INV   = 4'd4;
  localparam logic [3:0] FN_CONST = 4'd14;

  // transistor cost per func code
  function automatic logic [3:0] gate_cost(input logic [3:0] f);
    logic [3:0] r;
    case (f)
      4'd0, 4'd2, 4'd8, 4'd10, 4'd11: r = 4'd6;
      4'd1, 4'd3, 4'd13:              r = 4'd8;
      4'd4:                           r = 4'd2;
      4'd5, 4'd12:                    r = 4'd10;
      4'd6:                           r = 4'd12;
      4'd7, 4'd9:                     r = 4'd4;
      default:                        r = 4'd0;
    endcase
    return r;
  endfunction

  // number of source fields a func code reads
  function automatic logic [1:0] gate_arity(input logic [3:0] f);
    logic [1:0] r;
    case (f)
      4'd4:                          r = 2'd1;
      4'd0, 4'd2, 4'd5, 4'd7, 4'd9:  r = 2'd2;
      4'd14, 4'd15:                  r = 2'd0;
      default:                       r = 2'd3;
    endcase
    return r;
  endfunction

  function automatic logic is_gate(input logic [3:0] f);
    return f < FN_CONST;
  endfunction

endpackage

// File: rtl/fit_err_acc.sv
module fit_err_acc #(
  parameter int NI = 3,
  parameter int NO = 2,
  localparam int NV = 1 << NI,
  localparam int VW = $clog2(NV + 1),
  localparam int EW = $clog2(NO * NV + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          vec_valid,
  output logic          vec_ready,
  input  logic [NO-1:0] vec_obs,
  input  logic [NO-1:0] vec_exp,
  output logic [EW-1:0] err_sum,
  output logic          err_done
);

  logic          run;
  logic [VW-1:0] beats;
  logic [EW-1:0] ones;
  logic          take;

  assign vec_ready = run;
  assign take      = run && vec_valid;

  always_comb begin
    ones = '0;
    for (int i = 0; i < NO; i++) ones = ones + EW'(vec_obs[i] ^ vec_exp[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      beats    <= '0;
      err_sum  <= '0;
      err_done <= 1'b0;
    end else if (start) begin
      run      <= 1'b1;
      beats    <= '0;
      err_sum  <= '0;
      err_done <= 1'b0;
    end else if (take) begin
      err_sum <= err_sum + ones;
      beats   <= beats + 1'b1;
      if (beats == VW'(NV - 1)) begin
        run      <= 1'b0;
        err_done <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/fit_pheno.sv
module fit_pheno
  import fit_pkg::*;
#(
  parameter int NI = 3,
  parameter int NO = 2,
  parameter int NN = 8,
  localparam int NS = NI + NN,
  localparam int IW = $clog2(NS),
  localparam int NG = NN + NO,
  localparam int AW = $clog2(NG),
  localparam int GW = FUNC_W + 3 * IW,
  localparam int KW = (NN > 1) ? $clog2(NN) : 1,
  localparam int OW = (NO > 1) ? $clog2(NO) : 1,
  localparam int BW = $clog2(16 * NN + 1),
  localparam int CW = $clog2(NN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic [AW-1:0] chr_addr,
  input  logic [GW-1:0] chr_data,
  output logic [BW-1:0] b_sum,
  output logic [CW-1:0] c_cnt,
  output logic [CW-1:0] d_max,
  output logic          ph_done
);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_MARK, S_WALK, S_FIN} ph_state_t;

  localparam logic [IW-1:0] NI_V = IW'(NI);

  ph_state_t     st;
  logic [AW-1:0] ac;
  logic [KW-1:0] k;
  logic [NN-1:0] act;

  logic [IW-1:0]   nsrc [NN][3];
  logic [3:0]      nfun [NN];
  logic [IW-1:0]   osrc [NO];
  logic [CW-1:0]   dep  [NN];

  logic [3:0]    ld_fun;
  logic [OW-1:0] oidx;
  logic [CW-1:0] new_dep;
  logic [CW-1:0] out_dep;

  function automatic logic names_node(input logic [IW-1:0] s);
    return (int'(s) >= NI) && (int'(s) < NS);
  endfunction

  function automatic logic [KW-1:0] node_of(input logic [IW-1:0] s);
    logic [IW-1:0] t;
    t = s - NI_V;
    return t[KW-1:0];
  endfunction

  assign chr_addr = ac;
  assign ld_fun   = chr_data[GW-1 -: FUNC_W];
  assign oidx     = OW'(ac - AW'(NN));

  // depth of the node under the forward walk
  always_comb begin
    logic [CW-1:0] mx;
    mx = '0;
    for (int j = 0; j < 3; j++) begin
      if (j < int'(gate_arity(nfun[k])) && names_node(nsrc[k][j]))
        if (dep[node_of(nsrc[k][j])] > mx) mx = dep[node_of(nsrc[k][j])];
    end
    new_dep = is_gate(nfun[k]) ? mx + 1'b1 : '0;
  end

  // deepest node named by an output gene
  always_comb begin
    out_dep = '0;
    for (int o = 0; o < NO; o++) begin
      if (names_node(osrc[o]) && dep[node_of(osrc[o])] > out_dep)
        out_dep = dep[node_of(osrc[o])];
    end
  end

  // decoded gene store
  always_ff @(posedge clk) begin
    if (st == S_LOAD) begin
      if (int'(ac) < NN) begin
        nfun[ac[KW-1:0]] <= ld_fun;
        for (int j = 0; j < 3; j++) nsrc[ac[KW-1:0]][j] <= chr_data[j*IW +: IW];
      end else begin
        osrc[oidx] <= chr_data[IW-1:0];
      end
    end
    if (st == S_WALK) dep[k] <= new_dep;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ac      <= '0;
      k       <= '0;
      act     <= '0;
      b_sum   <= '0;
      c_cnt   <= '0;
      d_max   <= '0;
      ph_done <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (start) begin
            st      <= S_LOAD;
            ac      <= '0;
            act     <= '0;
            ph_done <= 1'b0;
          end
        end
        S_LOAD: begin
          if (int'(ac) >= NN && names_node(chr_data[IW-1:0]))
            act[node_of(chr_data[IW-1:0])] <= 1'b1;
          if (int'(ac) == NG - 1) begin
            st <= S_MARK;
            k  <= KW'(NN - 1);
          end else begin
            ac <= ac + 1'b1;
          end
        end
        S_MARK: begin
          if (act[k]) begin
            for (int j = 0; j < 3; j++) begin
              if (j < int'(gate_arity(nfun[k])) && names_node(nsrc[k][j]))
                act[node_of(nsrc[k][j])] <= 1'b1;
            end
          end
          if (k == '0) begin
            st    <= S_WALK;
            b_sum <= '0;
            c_cnt <= '0;
          end else begin
            k <= k - 1'b1;
          end
        end
        S_WALK: begin
          if (act[k] && is_gate(nfun[k])) begin
            b_sum <= b_sum + BW'(gate_cost(nfun[k]));
            c_cnt <= c_cnt + 1'b1;
          end
          if (int'(k) == NN - 1) st <= S_FIN;
          else k <= k + 1'b1;
        end
        S_FIN: begin
          d_max   <= out_dep;
          ph_done <= 1'b1;
          ac      <= '0;
          st      <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fit_weigh.sv
module fit_weigh #(
  parameter int NN   = 8,
  parameter int EW   = 5,
  parameter int BW   = 8,
  parameter int CW   = 4,
  parameter int FITW = 48
) (
  input  logic [EW-1:0]   a_err,
  input  logic [BW-1:0]   b_tr,
  input  logic [CW-1:0]   c_gt,
  input  logic [CW-1:0]   d_dl,
  output logic [FITW-1:0] fit
);

  localparam longint G1 = longint'(NN) + 1;
  localparam longint G2 = G1 * G1;
  localparam longint G3 = (16 * longint'(NN) + 1) * G2;

  logic [63:0] total;

  assign total = 64'd1
               + 64'(a_err) * 64'(G3)
               + 64'(b_tr)  * 64'(G2)
               + 64'(c_gt)  * 64'(G1)
               + 64'(d_dl);
  assign fit = total[FITW-1:0];

endmodule

// File: rtl/fit_scorer.sv
module fit_scorer
  import fit_pkg::*;
#(
  parameter int NI   = 3,
  parameter int NO   = 2,
  parameter int NN   = 8,
  parameter int FITW = 48,
  localparam int NS = NI + NN,
  localparam int IW = $clog2(NS),
  localparam int AW = $clog2(NN + NO),
  localparam int GW = FUNC_W + 3 * IW,
  localparam int EW = $clog2(NO * (1 << NI) + 1),
  localparam int BW = $clog2(16 * NN + 1),
  localparam int CW = $clog2(NN + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            busy,
  output logic            done,
  output logic [FITW-1:0] fitness,
  output logic [AW-1:0]   chr_addr,
  input  logic [GW-1:0]   chr_data,
  input  logic            vec_valid,
  output logic            vec_ready,
  input  logic [NO-1:0]   vec_obs,
  input  logic [NO-1:0]   vec_exp
);

  logic            go;
  logic [EW-1:0]   err_sum;
  logic            err_done;
  logic [BW-1:0]   b_sum;
  logic [CW-1:0]   c_cnt;
  logic [CW-1:0]   d_max;
  logic            ph_done;
  logic [FITW-1:0] fit_w;

  assign go = start && !busy;

  fit_err_acc #(.NI(NI), .NO(NO)) u_err (
    .clk, .rst_n, .start(go),
    .vec_valid, .vec_ready, .vec_obs, .vec_exp,
    .err_sum, .err_done
  );

  fit_pheno #(.NI(NI), .NO(NO), .NN(NN)) u_pheno (
    .clk, .rst_n, .start(go),
    .chr_addr, .chr_data,
    .b_sum, .c_cnt, .d_max, .ph_done
  );

  fit_weigh #(.NN(NN), .EW(EW), .BW(BW), .CW(CW), .FITW(FITW)) u_weigh (
    .a_err(err_sum), .b_tr(b_sum), .c_gt(c_cnt), .d_dl(d_max), .fit(fit_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      fitness <= '0;
    end else begin
      done <= 1'b0;
      if (go) begin
        busy <= 1'b1;
      end else if (busy && err_done && ph_done) begin
        busy    <= 1'b0;
        done    <= 1'b1;
        fitness <= fit_w;
      end
    end
  end

endmodule

// File: rtl/fit_scorer_chk.sv
module fit_scorer_chk #(
  parameter int NI   = 3,
  parameter int NO   = 2,
  parameter int NN   = 8,
  parameter int FITW = 48,
  parameter int AW   = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic [FITW-1:0] fitness,
  input logic [AW-1:0]   chr_addr,
  input logic            vec_valid,
  input logic            vec_ready
);

  localparam int NV = 1 << NI;

  int beats;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beats <= 0;
    else if (start && !busy) beats <= 0;
    else if (vec_valid && vec_ready) beats <= beats + 1;
  end

  p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_addr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(chr_addr) < NN + NO));

  p_ready_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vec_ready |-> busy);

  p_beat_total_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> beats == NV);

  p_fit_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> fitness != '0);

  p_fit_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(fitness));

endmodule

bind fit_scorer fit_scorer_chk #(
  .NI(NI), .NO(NO), .NN(NN), .FITW(FITW), .AW(AW)
) u_fit_scorer_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .fitness(fitness), .chr_addr(chr_addr),
  .vec_valid(vec_valid), .vec_ready(vec_ready)
);

// File: tb/test_fit_scorer.sv
module test_fit_scorer;

  localparam int NI = 3;
  localparam int NO = 2;
  localparam int NN = 8;
  localparam int FITW = 48;
  localparam int NS = NI + NN;
  localparam int IW = $clog2(NS);
  localparam int AW = $clog2(NN + NO);
  localparam int GW = 4 + 3 * IW;
  localparam int NV = 1 << NI;
  localparam longint G1 = NN + 1;
  localparam longint G2 = G1 * G1;
  localparam longint G3 = (16 * NN + 1) * G2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic            busy, done;
  logic [FITW-1:0] fitness;
  logic [AW-1:0]   chr_addr;
  logic [GW-1:0]   chr_data;
  logic            vec_valid = 1'b0;
  logic            vec_ready;
  logic [NO-1:0]   vec_obs = '0;
  logic [NO-1:0]   vec_exp = '0;

  logic [GW-1:0] mem [NN + NO];
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  assign chr_data = (int'(chr_addr) < NN + NO) ? mem[chr_addr] : '0;

  fit_scorer #(.NI(NI), .NO(NO), .NN(NN), .FITW(FITW)) i_fit_scorer (
    .clk, .rst_n, .start, .busy, .done, .fitness,
    .chr_addr, .chr_data, .vec_valid, .vec_ready, .vec_obs, .vec_exp
  );

  task automatic chk(input bit ok, input string req, input longint got, input longint want);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, want);
    end
  endtask

  function automatic int cost_of(input int f);
    case (f)
      0, 2, 8, 10, 11: return 6;
      1, 3, 13:        return 8;
      4:               return 2;
      5, 12:           return 10;
      6:               return 12;
      7, 9:            return 4;
      default:         return 0;
    endcase
  endfunction

  function automatic int uses_of(input int f);
    if (f == 4) return 1;
    if (f == 0 || f == 2 || f == 5 || f == 7 || f == 9) return 2;
    if (f >= 14) return 0;
    return 3;
  endfunction

  function automatic int field(input int addr, input int j);
    return int'(mem[addr][j*IW +: IW]);
  endfunction

  function automatic longint model_fit(input int a);
    bit act [NN];
    int dep [NN];
    int b, c, d, s, f, m;
    b = 0; c = 0; d = 0;
    for (int k = 0; k < NN; k++) begin act[k] = 0; dep[k] = 0; end
    for (int o = 0; o < NO; o++) begin
      s = field(NN + o, 0);
      if (s >= NI && s < NS) act[s - NI] = 1;
    end
    for (int k = NN - 1; k >= 0; k--) begin
      f = int'(mem[k][GW-1 -: 4]);
      if (act[k])
        for (int j = 0; j < uses_of(f); j++) begin
          s = field(k, j);
          if (s >= NI && s < NS) act[s - NI] = 1;
        end
    end
    for (int k = 0; k < NN; k++) begin
      f = int'(mem[k][GW-1 -: 4]);
      m = 0;
      for (int j = 0; j < uses_of(f); j++) begin
        s = field(k, j);
        if (s >= NI && s < NS && dep[s - NI] > m) m = dep[s - NI];
      end
      dep[k] = (f < 14) ? m + 1 : 0;
      if (act[k] && f < 14) begin b += cost_of(f); c++; end
    end
    for (int o = 0; o < NO; o++) begin
      s = field(NN + o, 0);
      if (s >= NI && s < NS && dep[s - NI] > d) d = dep[s - NI];
    end
    return 1 + longint'(a) * G3 + longint'(b) * G2 + longint'(c) * G1 + longint'(d);
  endfunction

  function automatic logic [GW-1:0] node(input int f, input int s0, input int s1, input int s2);
    return {4'(f), IW'(s2), IW'(s1), IW'(s0)};
  endfunction

  task automatic rand_chromo();
    for (int k = 0; k < NN; k++)
      mem[k] = node($urandom % 16, $urandom % (NI + k), $urandom % (NI + k), $urandom % (NI + k));
    for (int o = 0; o < NO; o++) mem[NN + o] = GW'($urandom % NS);
  endtask

  // mode 0 random bits, 1 all match, 2 all mismatch
  task automatic run_job(input string req, input int mode, input int stall, input bit restart);
    int a = 0, beats = 0, cyc = 0;
    bit got = 0, addr_ok = 1, rdy_ok = 1;
    logic [NO-1:0] e;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy === 1'b1, "R1 busy after start", busy, 1);
    while (!got) begin
      if (done) begin
        got = 1;
        break;
      end
      if (busy && int'(chr_addr) >= NN + NO) addr_ok = 0;
      if (beats == NV && vec_ready) rdy_ok = 0;
      start = (restart && cyc == 3);
      e = NO'($urandom);
      vec_exp = e;
      vec_obs = (mode == 1) ? e : (mode == 2) ? ~e : NO'($urandom);
      vec_valid = (beats < NV) && (int'($urandom % 100) >= stall);
      if (vec_valid && vec_ready) begin
        beats++;
        for (int i = 0; i < NO; i++) a += int'(vec_obs[i] ^ vec_exp[i]);
      end
      cyc++;
      if (cyc > 3000) break;
      @(negedge clk);
    end
    vec_valid = 1'b0;
    start = 1'b0;
    chk(got, "R1 job finished", got, 1);
    chk(addr_ok, "R2 address in range", addr_ok, 1);
    chk(rdy_ok && beats == NV, "R3 beat count and ready drop", beats, NV);
    chk(fitness == FITW'(model_fit(a)), req, longint'(fitness), model_fit(a));
    chk(!busy && !vec_ready, "R1 idle after done", busy, 0);
    if (restart) begin
      bit extra = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (done || busy) extra = 1;
      end
      chk(!extra, "R1 start while busy ignored", extra, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R1 watchdog expired", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    for (int k = 0; k < NN + NO; k++) mem[k] = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !vec_ready, "R1 reset outputs", busy, 0);
    chk(fitness == '0, "R9 reset fitness", longint'(fitness), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: outputs straight from inputs, matching vectors -> fitness 1
    rand_chromo();
    mem[NN] = GW'(0);
    mem[NN + 1] = GW'(2);
    run_job("R5 input-only outputs", 1, 20, 0);
    chk(fitness == 1, "R5 fitness is one", longint'(fitness), 1);

    // R8: chain of two-input ANDs through every node, delay NN
    for (int k = 0; k < NN; k++)
      mem[k] = node(0, (k == 0) ? 0 : NI + k - 1, 1, 2);
    mem[NN] = GW'(NI + NN - 1);
    mem[NN + 1] = GW'(1);
    run_job("R8 chain delay", 1, 0, 0);
    chk(fitness == 1 + 6 * NN * G2 + NN * G1 + NN, "R8 chain exact", longint'(fitness),
        1 + 6 * NN * G2 + NN * G1 + NN);

    // R7: inverter whose unused fields name node 0
    for (int k = 0; k < NN; k++) mem[k] = node(6, 0, 1, 2);
    mem[1] = node(4, 0, NI, NI);
    mem[NN] = GW'(NI + 1);
    mem[NN + 1] = GW'(NI + 1);
    run_job("R7 unused fields", 1, 30, 0);
    chk(fitness == 1 + 2 * G2 + G1 + 1, "R7 inverter only", longint'(fitness), 1 + 2 * G2 + G1 + 1);

    // R10: constant node feeding a select gate
    for (int k = 0; k < NN; k++) mem[k] = node(1, 0, 1, 2);
    mem[0] = node(15, 1, 2, 0);
    mem[1] = node(12, NI, 1, 2);
    mem[NN] = GW'(NI + 1);
    mem[NN + 1] = GW'(0);
    run_job("R10 constant node", 2, 10, 0);

    // R4: every bit wrong, with restart attempt mid-job (R1)
    rand_chromo();
    run_job("R4 all mismatch", 2, 40, 1);

    // R6 / R9: random chromosomes and vectors
    for (int t = 0; t < 8; t++) begin
      rand_chromo();
      run_job((t % 2 == 0) ? "R6 random cost" : "R9 random fitness", 0, 50, 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule